// File: doc/BRIEF.md
# Three-Plane Overlay Pixel Compositor

The compositor merges up to three overlay bitmap planes onto an external video pixel at a rate of one pixel per clock. Each plane supplies a pixel in one of two forms. The first is direct 16-bit colour in 5/6/5 red/green/blue layout. The second is an 8-bit index into a shared 256-entry colour table that holds 24-bit colours. Both forms are widened to a common 24-bit RGB value before mixing.

A programmable order register sets which plane sits in front. The planes are then mixed over the external pixel from back to front, using a 4-bit (16-step) alpha level supplied with every pixel. The block drives the composited pixel and an active-low superimpose flag. The flag tells downstream logic whether overlay content is visible at that pixel. The colour table is loaded through a simple write port while pixels keep flowing.

Top module: `osd_compositor`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0, `out_rgb` is 0 and `out_ys_n` is 1. Every colour table entry also resets to 0.
- R2: A plane with its `in_plane_pal` bit at 0 takes its 16-bit word as direct colour: red in [15:11], green in [10:5], blue in [4:0]. Each field is widened to 8 bits by placing it in the upper bits and filling the low bits with its own top bits (red and blue repeat their top 3 bits, green its top 2).
- R3: A plane with its `in_plane_pal` bit at 1 uses bits [7:0] of its word as a colour table index. The 24-bit entry, laid out red [23:16], green [15:8], blue [7:0], is its colour. Bits [15:8] of the word have no effect.
- R4: When `pal_wr_en` is high at a clock edge, entry `pal_wr_addr` takes `pal_wr_rgb`. Pixels presented in the same cycle as the write still see the old entry. Pixels presented in later cycles see the new one.
- R5: `cfg_order` holds one 2-bit plane number per depth slot: slot 0 (front) in [1:0], slot 1 in [3:2], slot 2 (back) in [5:4]. If any slot holds 3, or two slots hold the same number, the order used is plane 0 in front, then plane 1, with plane 2 at the back.
- R6: Mixing starts from the external pixel and applies the slots from back to front. Each channel becomes floor((a*plane + (15-a)*below)/15), where `a` is that plane's 4-bit alpha. An alpha of 15 in the front slot shows that plane's colour unchanged.
- R7: A plane whose `in_plane_en` bit is 0 acts as alpha 0, whatever alpha it carries. If every plane's effective alpha is 0, `out_rgb` equals the external pixel and `out_ys_n` is 1. Otherwise `out_ys_n` is 0.
- R8: A pixel presented with `in_valid` high at clock edge k appears on `out_rgb` and `out_ys_n` after edge k+1. At that point `out_valid` is high. `out_valid` equals `in_valid` delayed by two clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input pixel is valid |
| in_ext_rgb | input | 24 | External video pixel, R[23:16] G[15:8] B[7:0] |
| in_plane_pix | input | 48 | Plane words, plane p in [16p+15:16p] |
| in_plane_pal | input | 3 | Per plane: 1 = colour table index, 0 = direct 5/6/5 colour |
| in_plane_en | input | 3 | Per plane enable |
| in_plane_alpha | input | 12 | Per plane 4-bit alpha, plane p in [4p+3:4p] |
| cfg_order | input | 6 | Plane number for each depth slot, slot 0 in front |
| pal_wr_en | input | 1 | Colour table write strobe |
| pal_wr_addr | input | 8 | Colour table write index |
| pal_wr_rgb | input | 24 | Colour table write data |
| out_valid | output | 1 | Output pixel is valid |
| out_rgb | output | 24 | Composited pixel |
| out_ys_n | output | 1 | Low when overlay content is visible |

## Verification
A wrong colour table entry shows up only when a plane actually indexes that entry. The bench therefore reads each written entry in the cycle of the write and in the cycle after, catching both a stale and a premature update two clocks after the pixel enters. A wrong order decode or widening error changes the very next composited pixel that uses opaque planes of distinct colours. Rounding or weighting faults in the mix appear as small channel differences under random alphas. Stage misalignment shows as `out_valid` pulses that no longer line up with the input gaps.

// File: rtl/osd_pkg.sv
package osd_pkg;
  typedef struct packed {
    logic [7:0] r;
    logic [7:0] g;
    logic [7:0] b;
  } rgb_t;

  // 5/6/5 word to 8/8/8 by bit replication
  function automatic rgb_t widen_565(input logic [15:0] w);
    rgb_t c;
    c.r = {w[15:11], w[15:13]};
    c.g = {w[10:5],  w[10:9]};
    c.b = {w[4:0],   w[4:2]};
    return c;
  endfunction
endpackage

// File: rtl/osd_palette.sv
module osd_palette import osd_pkg::*; #(
  parameter int DEPTH = 256,
  parameter int PORTS = 3,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [AW-1:0]       wr_addr,
  input  rgb_t                wr_rgb,
  input  logic [PORTS*AW-1:0] rd_addr,
  output rgb_t [PORTS-1:0]    rd_rgb
);
  rgb_t mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_addr] <= wr_rgb;
    end
  end

  always_comb begin
    for (int p = 0; p < PORTS; p++) rd_rgb[p] = mem[rd_addr[p*AW +: AW]];
  end

  // R4: a write is visible in the next cycle
  p_table_update_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> mem[$past(wr_addr)] == $past(wr_rgb));
endmodule

// File: rtl/osd_plane_fmt.sv
module osd_plane_fmt import osd_pkg::*; #(
  parameter int IDX_W = 8
) (
  input  logic [15:0]      pix,
  input  logic             use_table,
  input  rgb_t             table_rgb,
  output logic [IDX_W-1:0] table_idx,
  output rgb_t             rgb
);
  assign table_idx = pix[IDX_W-1:0];
  assign rgb       = use_table ? table_rgb : widen_565(pix);
endmodule

// File: rtl/osd_order_sel.sv
module osd_order_sel #(
  parameter int PLANES = 3,
  localparam int IDX_W = $clog2(PLANES)
) (
  input  logic [PLANES*IDX_W-1:0] cfg,
  output logic [PLANES*IDX_W-1:0] order,
  output logic                    legal
);
  localparam logic [IDX_W:0] LIMIT = (IDX_W+1)'(PLANES);

  always_comb begin
    legal = 1'b1;
    for (int s = 0; s < PLANES; s++) begin
      if ({1'b0, cfg[s*IDX_W +: IDX_W]} >= LIMIT) legal = 1'b0;
      for (int t = s + 1; t < PLANES; t++)
        if (cfg[s*IDX_W +: IDX_W] == cfg[t*IDX_W +: IDX_W]) legal = 1'b0;
    end
    for (int s = 0; s < PLANES; s++)
      order[s*IDX_W +: IDX_W] = legal ? cfg[s*IDX_W +: IDX_W] : IDX_W'(s);
  end
endmodule

// File: rtl/osd_blend.sv
module osd_blend import osd_pkg::*; #(
  parameter int PLANES = 3,
  parameter int AW     = 4
) (
  input  rgb_t                  ext_rgb,
  input  rgb_t [PLANES-1:0]     slot_rgb,
  input  logic [PLANES*AW-1:0]  slot_a,
  output rgb_t                  mix_rgb,
  output logic                  any_ovl
);
  localparam int AMAX = (1 << AW) - 1;
  localparam int NW   = AW + 9;

  function automatic logic [7:0] mix_ch(input logic [AW-1:0] a,
                                        input logic [7:0] f,
                                        input logic [7:0] b);
    logic [NW-1:0] num;
    num = NW'(a) * NW'(f) + NW'(AW'(AMAX) - a) * NW'(b);
    return 8'(num / NW'(AMAX));
  endfunction

  always_comb begin
    rgb_t acc;
    logic [AW-1:0] a;
    acc = ext_rgb;
    for (int s = PLANES - 1; s >= 0; s--) begin
      a     = slot_a[s*AW +: AW];
      acc.r = mix_ch(a, slot_rgb[s].r, acc.r);
      acc.g = mix_ch(a, slot_rgb[s].g, acc.g);
      acc.b = mix_ch(a, slot_rgb[s].b, acc.b);
    end
    mix_rgb = acc;
    any_ovl = |slot_a;
  end
endmodule

// File: rtl/osd_compositor.sv
module osd_compositor import osd_pkg::*; #(
  parameter int PLANES    = 3,
  parameter int AW        = 4,
  parameter int PAL_DEPTH = 256,
  localparam int IDX_W    = $clog2(PLANES),
  localparam int PAL_AW   = $clog2(PAL_DEPTH)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [23:0]            in_ext_rgb,
  input  logic [PLANES*16-1:0]   in_plane_pix,
  input  logic [PLANES-1:0]      in_plane_pal,
  input  logic [PLANES-1:0]      in_plane_en,
  input  logic [PLANES*AW-1:0]   in_plane_alpha,
  input  logic [PLANES*IDX_W-1:0] cfg_order,
  input  logic                   pal_wr_en,
  input  logic [PAL_AW-1:0]      pal_wr_addr,
  input  logic [23:0]            pal_wr_rgb,
  output logic                   out_valid,
  output logic [23:0]            out_rgb,
  output logic                   out_ys_n
);
  localparam logic [AW-1:0] A_OPAQUE = '1;

  // stage 0: format, table lookup, alpha gating, ordering
  logic [PLANES*PAL_AW-1:0] tbl_addr;
  rgb_t [PLANES-1:0]        tbl_rgb;
  rgb_t [PLANES-1:0]        pl_rgb;
  logic [PLANES*AW-1:0]     pl_a;
  logic [PLANES*IDX_W-1:0]  order;
  logic                     order_legal;
  rgb_t [PLANES-1:0]        slot_rgb;
  logic [PLANES*AW-1:0]     slot_a;
  logic [PLANES-1:0]        slot_mask;

  osd_palette #(.DEPTH(PAL_DEPTH), .PORTS(PLANES)) u_table (
    .clk(clk), .rst_n(rst_n), .wr_en(pal_wr_en), .wr_addr(pal_wr_addr),
    .wr_rgb(pal_wr_rgb), .rd_addr(tbl_addr), .rd_rgb(tbl_rgb));

  for (genvar p = 0; p < PLANES; p++) begin : g_plane
    osd_plane_fmt #(.IDX_W(PAL_AW)) u_fmt (
      .pix(in_plane_pix[p*16 +: 16]), .use_table(in_plane_pal[p]),
      .table_rgb(tbl_rgb[p]), .table_idx(tbl_addr[p*PAL_AW +: PAL_AW]),
      .rgb(pl_rgb[p]));
    assign pl_a[p*AW +: AW] = in_plane_en[p] ? in_plane_alpha[p*AW +: AW] : '0;
  end

  osd_order_sel #(.PLANES(PLANES)) u_order (
    .cfg(cfg_order), .order(order), .legal(order_legal));

  always_comb begin
    slot_mask = '0;
    for (int s = 0; s < PLANES; s++) begin
      slot_rgb[s]         = pl_rgb[order[s*IDX_W +: IDX_W]];
      slot_a[s*AW +: AW]  = pl_a[order[s*IDX_W +: IDX_W]*AW +: AW];
      slot_mask[order[s*IDX_W +: IDX_W]] = 1'b1;
    end
  end

  // stage 1 registers
  logic                 s1_valid;
  rgb_t                 s1_ext;
  rgb_t [PLANES-1:0]    s1_slot_rgb;
  logic [PLANES*AW-1:0] s1_slot_a;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid    <= 1'b0;
      s1_ext      <= '0;
      s1_slot_rgb <= '0;
      s1_slot_a   <= '0;
    end else begin
      s1_valid    <= in_valid;
      s1_ext      <= in_ext_rgb;
      s1_slot_rgb <= slot_rgb;
      s1_slot_a   <= slot_a;
    end
  end

  // stage 1 mix, stage 2 output registers
  rgb_t mix_rgb;
  logic any_ovl;

  osd_blend #(.PLANES(PLANES), .AW(AW)) u_blend (
    .ext_rgb(s1_ext), .slot_rgb(s1_slot_rgb), .slot_a(s1_slot_a),
    .mix_rgb(mix_rgb), .any_ovl(any_ovl));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_rgb   <= '0;
      out_ys_n  <= 1'b1;
    end else begin
      out_valid <= s1_valid;
      out_rgb   <= mix_rgb;
      out_ys_n  <= ~any_ovl;
    end
  end

  // R5: the resolved order always covers every plane exactly once
  p_order_perm_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(slot_mask) == PLANES);
  // R6: an opaque front slot passes its colour through unchanged
  p_opaque_front_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_slot_a[AW-1:0] == A_OPAQUE) |=> out_rgb == $past(s1_slot_rgb[0]));
  // R7: with nothing visible the external pixel passes and the flag stays high
  p_clear_passthru_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_slot_a == '0) |=> (out_rgb == $past(s1_ext)) && out_ys_n);
  // R8: valid follows the pixel through the second stage
  p_valid_align_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(s1_valid));
endmodule

// File: tb/test_osd_compositor.sv
module test_osd_compositor;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n;
  logic        in_valid;
  logic [23:0] in_ext_rgb;
  logic [47:0] in_plane_pix;
  logic [2:0]  in_plane_pal, in_plane_en;
  logic [11:0] in_plane_alpha;
  logic [5:0]  cfg_order;
  logic        pal_wr_en;
  logic [7:0]  pal_wr_addr;
  logic [23:0] pal_wr_rgb;
  logic        out_valid, out_ys_n;
  logic [23:0] out_rgb;

  osd_compositor i_osd_compositor (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ext_rgb(in_ext_rgb),
    .in_plane_pix(in_plane_pix), .in_plane_pal(in_plane_pal),
    .in_plane_en(in_plane_en), .in_plane_alpha(in_plane_alpha),
    .cfg_order(cfg_order), .pal_wr_en(pal_wr_en), .pal_wr_addr(pal_wr_addr),
    .pal_wr_rgb(pal_wr_rgb), .out_valid(out_valid), .out_rgb(out_rgb),
    .out_ys_n(out_ys_n));

  int checks = 0, failures = 0;
  bit done = 0;
  int unsigned mpal [256];
  string cur_tag = "R8";
  bit pv = 0; logic [23:0] prgb = '0; bit pys = 1; string ptag = "";

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] m_widen(logic [15:0] w);
    int r, g, b;
    r = int'(w >> 11) & 31; g = int'(w >> 5) & 63; b = int'(w) & 31;
    r = (r << 3) | (r >> 2); g = (g << 2) | (g >> 4); b = (b << 3) | (b >> 2);
    return {r[7:0], g[7:0], b[7:0]};
  endfunction

  function automatic int m_mix(int a, int f, int b);
    return (a * f + (15 - a) * b) / 15;
  endfunction

  task automatic model(output logic [23:0] rgb, output bit ys);
    int ord[3], al[3], sel[3];
    logic [23:0] col[3];
    bit legal = 1;
    int r, g, b;
    for (int p = 0; p < 3; p++) begin
      logic [15:0] w = in_plane_pix[p*16 +: 16];
      col[p] = in_plane_pal[p] ? mpal[w[7:0]][23:0] : m_widen(w);
      al[p]  = in_plane_en[p] ? int'(in_plane_alpha[p*4 +: 4]) : 0;
      sel[p] = int'(cfg_order[p*2 +: 2]);
      if (sel[p] > 2) legal = 0;
    end
    if (sel[0] == sel[1] || sel[0] == sel[2] || sel[1] == sel[2]) legal = 0;
    for (int s = 0; s < 3; s++) ord[s] = legal ? sel[s] : s;
    r = int'(in_ext_rgb[23:16]); g = int'(in_ext_rgb[15:8]); b = int'(in_ext_rgb[7:0]);
    for (int s = 2; s >= 0; s--) begin
      r = m_mix(al[ord[s]], int'(col[ord[s]][23:16]), r);
      g = m_mix(al[ord[s]], int'(col[ord[s]][15:8]), g);
      b = m_mix(al[ord[s]], int'(col[ord[s]][7:0]), b);
    end
    rgb = {r[7:0], g[7:0], b[7:0]};
    ys  = (al[0] + al[1] + al[2]) == 0;
  endtask

  // one pixel: expected value from inputs now, compare output of two edges ago
  task automatic tick();
    logic [23:0] nrgb; bit nys; bit nv; string ntag;
    nv = in_valid; ntag = cur_tag;
    model(nrgb, nys);
    if (pal_wr_en) mpal[pal_wr_addr] = 32'(pal_wr_rgb);
    @(negedge clk);
    chk({"R8 out_valid (", ptag, ")"}, 32'(out_valid), 32'(pv));
    if (pv) begin
      chk({ptag, " out_rgb"}, 32'(out_rgb), 32'(prgb));
      chk({ptag, " out_ys_n"}, 32'(out_ys_n), 32'(pys));
    end
    pv = nv; prgb = nrgb; pys = nys; ptag = ntag;
  endtask

  task automatic set_plane(int p, bit pal, logic [15:0] w, logic [3:0] a, bit en);
    in_plane_pix[p*16 +: 16] = w;
    in_plane_pal[p] = pal;
    in_plane_alpha[p*4 +: 4] = a;
    in_plane_en[p] = en;
  endtask

  task automatic clear_planes();
    for (int p = 0; p < 3; p++) set_plane(p, 0, 16'h0, 4'h0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mpal[i] = 0;
    rst_n = 0; in_valid = 0; in_ext_rgb = 24'h102030; in_plane_pix = '0;
    in_plane_pal = '0; in_plane_en = '0; in_plane_alpha = '0;
    cfg_order = {2'd2, 2'd1, 2'd0}; pal_wr_en = 0; pal_wr_addr = '0; pal_wr_rgb = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 out_valid", 32'(out_valid), 32'd0);
    chk("R1 out_rgb", 32'(out_rgb), 32'd0);
    chk("R1 out_ys_n", 32'(out_ys_n), 32'd1);
    rst_n = 1;
    // R1: table reset to zero, read through opaque palette plane
    cur_tag = "R1"; in_valid = 1; set_plane(0, 1, 16'h0063, 4'hF, 1); tick();
    // R4: write and read same entry in the same cycle sees the old value; R3 upper bits ignored
    cur_tag = "R4"; pal_wr_en = 1; pal_wr_addr = 8'd5; pal_wr_rgb = 24'h123456;
    set_plane(0, 1, 16'h0005, 4'hF, 1); tick();
    cur_tag = "R4"; pal_wr_addr = 8'd200; pal_wr_rgb = 24'hABCDEF; tick();
    pal_wr_en = 0;
    cur_tag = "R3"; set_plane(0, 1, 16'hFF05, 4'hF, 1); tick();
    cur_tag = "R3"; set_plane(0, 1, 16'h37C8, 4'hF, 1); tick();
    // R2 direct colour fields
    cur_tag = "R2";
    set_plane(0, 0, 16'hF800, 4'hF, 1); tick();
    set_plane(0, 0, 16'h07E0, 4'hF, 1); tick();
    set_plane(0, 0, 16'h001F, 4'hF, 1); tick();
    set_plane(0, 0, 16'h8410, 4'hF, 1); tick();
    set_plane(0, 0, 16'h4A69, 4'hF, 1); tick();
    // R5 ordering with three opaque distinct planes
    cur_tag = "R5";
    set_plane(0, 0, 16'hF800, 4'hF, 1); set_plane(1, 0, 16'h07E0, 4'hF, 1);
    set_plane(2, 1, 16'h00C8, 4'hF, 1);
    cfg_order = {2'd2, 2'd1, 2'd0}; tick();
    cfg_order = {2'd1, 2'd0, 2'd2}; tick();
    cfg_order = {2'd0, 2'd2, 2'd1}; tick();
    cfg_order = {2'd0, 2'd1, 2'd1}; tick();
    cfg_order = {2'd3, 2'd0, 2'd1}; tick();
    // R6 partial alphas stacked over the external pixel
    cur_tag = "R6"; cfg_order = {2'd2, 2'd1, 2'd0};
    set_plane(0, 0, 16'hFFFF, 4'h8, 1); set_plane(1, 0, 16'h0000, 4'h3, 1);
    set_plane(2, 0, 16'h07E0, 4'hC, 1); in_ext_rgb = 24'h80FF01; tick();
    set_plane(0, 0, 16'h1234, 4'h1, 1); tick();
    // R7 disabled planes and zero alpha
    cur_tag = "R7"; in_ext_rgb = 24'h5A5A5A;
    set_plane(0, 0, 16'hFFFF, 4'hF, 0); set_plane(1, 0, 16'hFFFF, 4'hF, 0);
    set_plane(2, 0, 16'hFFFF, 4'hF, 0); tick();
    clear_planes(); in_plane_en = 3'b111; tick();
    set_plane(1, 0, 16'hFFFF, 4'h1, 1); tick();
    // R8 valid gaps
    cur_tag = "R8"; in_valid = 0; tick(); in_valid = 1; tick(); in_valid = 0; tick(); tick();
    in_valid = 1; tick();
    // constrained random mixed traffic
    void'($urandom(32'h0C0FFEE5));
    for (int n = 0; n < 600; n++) begin
      cur_tag = "R6 random";
      in_valid = ($urandom % 8) != 0;
      in_ext_rgb = 24'($urandom);
      for (int p = 0; p < 3; p++)
        set_plane(p, 1'($urandom), 16'($urandom), 4'($urandom), ($urandom % 4) != 0);
      cfg_order = (($urandom % 5) == 0) ? 6'($urandom) : {2'd2, 2'd1, 2'd0};
      if (($urandom % 3) == 0) cfg_order = {2'd0, 2'd2, 2'd1};
      pal_wr_en = ($urandom % 4) == 0;
      pal_wr_addr = 8'($urandom % 16);
      in_plane_pix[7:0] = 8'($urandom % 16);
      pal_wr_rgb = 24'($urandom);
      tick();
    end
    pal_wr_en = 0; in_valid = 0; tick(); tick();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule